// File: doc/BRIEF.md
# Counting Bloom Filter Update Controller

This block keeps a small reference counter behind every bit of a banked Bloom filter. Rule-management logic sends it insert and delete requests. Each request names a filter bank and carries a hash index. The block reads the counter for that bit and decides whether the filter itself must change. It sends a single set or clear record to the filter only when a counter moves from zero to one or from one to zero. It then waits for the filter to acknowledge or reject the write, and reports the outcome.

An insert whose filter write is rejected leaves the counter at zero, so the request can be retried. The caller must update the filter before it commits a rule to the exact-match table. If that table commit fails, the caller issues a delete for the same bank and hash, and the delete takes back the filter update.

All three interfaces that carry data use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Only one request is in flight at a time, and `req_ready` stays low from acceptance until the response has been taken. A filter record is held unchanged while `fw_valid` is high and `fw_ready` is low. The filter's `fw_ack`/`fw_err` pulse is sampled only in the cycles after the record handshake. A response is held unchanged while `rsp_valid` is high and `rsp_ready` is low. After reset an internal sweep clears every counter, and requests are refused until it has finished.

Top module: `bfc_ctrl`

## Requirements
- R1: After reset, `init_done` and `req_ready` stay low while a sweep writes zero to all NUM_BANKS×2^LOG_SIZE counters, one per cycle. `init_done` rises after exactly that many clock cycles. Every counter then reads as zero, including counters that held nonzero values before the reset.
- R2: The counter used is bank×2^LOG_SIZE + hash[LOG_SIZE-1:0]. Hash bits above LOG_SIZE are ignored. A filter record carries `fw_bank` equal to the request bank and `fw_index` equal to hash[LOG_SIZE-1:0].
- R3: An insert (`req_op`=0) that finds a counter between 1 and its maximum minus one increments the counter and sends no filter record (`rsp_wrote`=0).
- R4: An insert that finds a zero counter sends one record with `fw_state`=1 (set). Once `fw_ack` arrives, the counter becomes 1 and the response shows `rsp_wrote`=1, `rsp_err`=0 and `rsp_count`=1.
- R5: If the set record of R4 is answered with `fw_err`, the counter stays 0 and the response shows `rsp_err`=1 and `rsp_count`=0. A later insert of the same bit sends a set record again.
- R6: A delete (`req_op`=1) decrements the counter. A record with `fw_state`=0 (clear) is sent only when the counter goes from 1 to 0. If that clear is answered with `fw_err`, the counter is still 0 and `rsp_err`=1.
- R7: A delete that finds a zero counter changes nothing and sends no record. The response shows `rsp_underflow`=1 and `rsp_count`=0.
- R8: An insert that finds a counter at its maximum (2^CNT_W−1) leaves it there and sends no record. The response shows `rsp_overflow`=1 and `rsp_count`=2^CNT_W−1.
- R9: Requests are accepted one at a time, with `req_ready` low while an operation is in progress. The filter record and the response hold all of their fields stable under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | output | 1 | High once the counter-clearing sweep has finished |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = insert, 1 = delete |
| req_bank | input | BANK_W (2) | Filter bank number |
| req_hash | input | HASH_W (16) | Hash index of the rule |
| fw_valid | output | 1 | Filter update record valid |
| fw_ready | input | 1 | Filter accepts the record |
| fw_state | output | 1 | 1 = set bit, 0 = clear bit |
| fw_bank | output | BANK_W (2) | Bank of the bit to update |
| fw_index | output | LOG_SIZE (6) | Bit index inside the bank |
| fw_ack | input | 1 | Filter write completed |
| fw_err | input | 1 | Filter write failed (takes priority over fw_ack) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_wrote | output | 1 | A filter record was sent for this request |
| rsp_err | output | 1 | The filter rejected the record |
| rsp_underflow | output | 1 | Delete found a zero counter |
| rsp_overflow | output | 1 | Insert found a saturated counter |
| rsp_count | output | CNT_W (4) | Counter value after the operation |

## Verification
The main function is driven by a vector walk with several kinds of stimulus. Repeated inserts on one bit separate the increment-only path from the path that sets the filter bit. Two hashes that differ only above the index width, and equal hashes in different banks, show which counter each request reaches. Accept and reject answers from the filter separate a committed transition from a rolled-back one, and a delete chain run past zero exposes the underflow guard. Directed runs drive one counter into saturation, stall both the filter record and the response, and reset the block with nonzero counters to show that the sweep clears them.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic {
    OP_INSERT = 1'b0,
    OP_DELETE = 1'b1
  } bfc_op_e;

  typedef enum logic [2:0] {
    S_SWEEP,
    S_IDLE,
    S_READ,
    S_WREQ,
    S_WAIT,
    S_UPD,
    S_DONE
  } bfc_state_e;

endpackage

// File: rtl/bfc_addr_map.sv
module bfc_addr_map #(
  parameter int NUM_BANKS = 4,
  parameter int LOG_SIZE  = 6,
  parameter int HASH_W    = 16,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [BANK_W-1:0]   bank,
  input  logic [HASH_W-1:0]   hash,
  output logic [LOG_SIZE-1:0] idx,
  output logic [ADDR_W-1:0]   addr
);

  assign idx = hash[LOG_SIZE-1:0];

  generate
    if (HASH_W > LOG_SIZE) begin : g_hi
      logic unused_hash_hi;
      assign unused_hash_hi = ^hash[HASH_W-1:LOG_SIZE];
    end

    if (NUM_BANKS == 1) begin : g_single
      logic unused_bank;
      assign unused_bank = ^bank;
      assign addr = ADDR_W'(idx);
    end else begin : g_banked
      // bank * 2^LOG_SIZE + idx is a plain concatenation
      localparam int CAT_W = BANK_W + LOG_SIZE;
      logic [CAT_W-1:0] cat;
      assign cat  = {bank, idx};
      assign addr = cat[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/bfc_cnt_ram.sv
module bfc_cnt_ram #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/bfc_seq.sv
module bfc_seq
  import bfc_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int LOG_SIZE = 6,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 4,
  parameter int DEPTH    = 256
) (
  input  logic                clk,
  input  logic                rst,
  output logic                init_done,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_op,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [LOG_SIZE-1:0] req_idx,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                ram_re,
  output logic [ADDR_W-1:0]   ram_raddr,
  input  logic [CNT_W-1:0]    ram_q,
  output logic                ram_we,
  output logic [ADDR_W-1:0]   ram_waddr,
  output logic [CNT_W-1:0]    ram_wdata,
  output logic                fw_valid,
  input  logic                fw_ready,
  output logic                fw_state,
  output logic [BANK_W-1:0]   fw_bank,
  output logic [LOG_SIZE-1:0] fw_index,
  input  logic                fw_ack,
  input  logic                fw_err,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_wrote,
  output logic                rsp_err,
  output logic                rsp_underflow,
  output logic                rsp_overflow,
  output logic [CNT_W-1:0]    rsp_count
);

  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  bfc_state_e            st;
  bfc_op_e               op_q;
  logic [BANK_W-1:0]     bank_q;
  logic [LOG_SIZE-1:0]   idx_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [ADDR_W-1:0]     sweep_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  set_q;
  logic                  wrote_q;
  logic                  err_q;
  logic                  uf_q;
  logic                  of_q;
  logic                  init_q;
  logic                  accept;

  assign accept = (st == S_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_SWEEP;
      sweep_q <= '0;
      init_q  <= 1'b0;
      op_q    <= OP_INSERT;
      bank_q  <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      set_q   <= 1'b0;
      wrote_q <= 1'b0;
      err_q   <= 1'b0;
      uf_q    <= 1'b0;
      of_q    <= 1'b0;
    end else begin
      case (st)
        S_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == LAST_ADDR) begin
            st     <= S_IDLE;
            init_q <= 1'b1;
          end
        end
        S_IDLE: begin
          if (accept) begin
            op_q    <= bfc_op_e'(req_op);
            bank_q  <= req_bank;
            idx_q   <= req_idx;
            addr_q  <= req_addr;
            wrote_q <= 1'b0;
            err_q   <= 1'b0;
            uf_q    <= 1'b0;
            of_q    <= 1'b0;
            st      <= S_READ;
          end
        end
        S_READ: begin
          if (op_q == OP_INSERT) begin
            if (ram_q == '0) begin
              cnt_q   <= CNT_ONE;
              set_q   <= 1'b1;
              wrote_q <= 1'b1;
              st      <= S_WREQ;
            end else if (ram_q == CNT_MAX) begin
              cnt_q <= CNT_MAX;
              of_q  <= 1'b1;
              st    <= S_DONE;
            end else begin
              cnt_q <= ram_q + 1'b1;
              st    <= S_UPD;
            end
          end else begin
            if (ram_q == '0) begin
              cnt_q <= '0;
              uf_q  <= 1'b1;
              st    <= S_DONE;
            end else if (ram_q == CNT_ONE) begin
              cnt_q   <= '0;
              set_q   <= 1'b0;
              wrote_q <= 1'b1;
              st      <= S_WREQ;
            end else begin
              cnt_q <= ram_q - 1'b1;
              st    <= S_UPD;
            end
          end
        end
        S_WREQ: begin
          if (fw_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (fw_err) begin
            err_q <= 1'b1;
            if (op_q == OP_INSERT) begin
              cnt_q <= '0;
              st    <= S_DONE;
            end else begin
              st <= S_UPD;
            end
          end else if (fw_ack) begin
            st <= S_UPD;
          end
        end
        S_UPD: st <= S_DONE;
        S_DONE: begin
          if (rsp_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_re    = accept;
    ram_raddr = req_addr;
    ram_we    = (st == S_SWEEP) || (st == S_UPD);
    ram_waddr = (st == S_SWEEP) ? sweep_q : addr_q;
    ram_wdata = (st == S_SWEEP) ? '0 : cnt_q;
  end

  assign init_done     = init_q;
  assign req_ready     = (st == S_IDLE);
  assign fw_valid      = (st == S_WREQ);
  assign fw_state      = set_q;
  assign fw_bank       = bank_q;
  assign fw_index      = idx_q;
  assign rsp_valid     = (st == S_DONE);
  assign rsp_wrote     = wrote_q;
  assign rsp_err       = err_q;
  assign rsp_underflow = uf_q;
  assign rsp_overflow  = of_q;
  assign rsp_count     = cnt_q;

endmodule

// File: rtl/bfc_ctrl.sv
module bfc_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int LOG_SIZE  = 6,
  parameter int HASH_W    = 16,
  parameter int CNT_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  output logic                init_done,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_op,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [HASH_W-1:0]   req_hash,
  output logic                fw_valid,
  input  logic                fw_ready,
  output logic                fw_state,
  output logic [BANK_W-1:0]   fw_bank,
  output logic [LOG_SIZE-1:0] fw_index,
  input  logic                fw_ack,
  input  logic                fw_err,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_wrote,
  output logic                rsp_err,
  output logic                rsp_underflow,
  output logic                rsp_overflow,
  output logic [CNT_W-1:0]    rsp_count
);

  localparam int DEPTH  = NUM_BANKS * (1 << LOG_SIZE);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LOG_SIZE-1:0] req_idx;
  logic [ADDR_W-1:0]   req_addr;
  logic                ram_re;
  logic [ADDR_W-1:0]   ram_raddr;
  logic [CNT_W-1:0]    ram_q;
  logic                ram_we;
  logic [ADDR_W-1:0]   ram_waddr;
  logic [CNT_W-1:0]    ram_wdata;

  bfc_addr_map #(
    .NUM_BANKS(NUM_BANKS), .LOG_SIZE(LOG_SIZE), .HASH_W(HASH_W),
    .BANK_W(BANK_W), .ADDR_W(ADDR_W)
  ) map_i (
    .bank(req_bank), .hash(req_hash), .idx(req_idx), .addr(req_addr)
  );

  bfc_cnt_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(CNT_W)) ram_i (
    .clk(clk), .re(ram_re), .raddr(ram_raddr), .q(ram_q),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );

  bfc_seq #(
    .BANK_W(BANK_W), .LOG_SIZE(LOG_SIZE), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .DEPTH(DEPTH)
  ) seq_i (
    .clk(clk), .rst(rst), .init_done(init_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_idx(req_idx), .req_addr(req_addr),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_q(ram_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_state(fw_state),
    .fw_bank(fw_bank), .fw_index(fw_index), .fw_ack(fw_ack), .fw_err(fw_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_wrote(rsp_wrote),
    .rsp_err(rsp_err), .rsp_underflow(rsp_underflow),
    .rsp_overflow(rsp_overflow), .rsp_count(rsp_count)
  );

endmodule

// File: rtl/bfc_ctrl_chk.sv
module bfc_ctrl_chk #(
  parameter int BANK_W   = 2,
  parameter int LOG_SIZE = 6,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                init_done,
  input logic                req_ready,
  input logic                fw_valid,
  input logic                fw_ready,
  input logic                fw_state,
  input logic [BANK_W-1:0]   fw_bank,
  input logic [LOG_SIZE-1:0] fw_index,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_wrote,
  input logic                rsp_err,
  input logic                rsp_underflow,
  input logic                rsp_overflow,
  input logic [CNT_W-1:0]    rsp_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_READY_AFTER_SWEEP: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> init_done); // R1

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    fw_valid && !fw_ready |=> fw_valid && $stable({fw_state, fw_bank, fw_index})); // R9

  AST_RESPONSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_wrote, rsp_err, rsp_underflow, rsp_overflow, rsp_count})); // R9

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (rst)
    (fw_valid || rsp_valid) |-> !req_ready); // R9

  AST_UNDERFLOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_underflow |-> !rsp_wrote && rsp_count == '0); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_overflow |-> !rsp_wrote && rsp_count == CNT_MAX); // R8

  AST_ERR_LEAVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_wrote && rsp_count == '0); // R5 R6

endmodule

bind bfc_ctrl bfc_ctrl_chk #(.BANK_W(BANK_W), .LOG_SIZE(LOG_SIZE), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .init_done(init_done), .req_ready(req_ready),
  .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_state(fw_state),
  .fw_bank(fw_bank), .fw_index(fw_index),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_wrote(rsp_wrote),
  .rsp_err(rsp_err), .rsp_underflow(rsp_underflow),
  .rsp_overflow(rsp_overflow), .rsp_count(rsp_count)
);

// File: tb/bfc_ctrl_tb_top.sv
`timescale 1ns/1ps
module bfc_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_done, req_ready, fw_valid, fw_state, rsp_valid;
  logic        rsp_wrote, rsp_err, rsp_underflow, rsp_overflow;
  logic [1:0]  fw_bank;
  logic [5:0]  fw_index;
  logic [3:0]  rsp_count;
  logic        req_valid = 1'b0, req_op = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [15:0] req_hash = '0;
  logic        fw_ready = 1'b0, fw_ack = 1'b0, fw_err = 1'b0, rsp_ready = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  logic       r_saw, r_state, r_wrote, r_err, r_uf, r_of;
  logic [1:0] r_bank;
  logic [5:0] r_idx;
  logic [3:0] r_cnt;

  always #2.5 clk = ~clk;

  bfc_ctrl dut_i (
    .clk(clk), .rst(rst), .init_done(init_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_hash(req_hash),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_state(fw_state),
    .fw_bank(fw_bank), .fw_index(fw_index), .fw_ack(fw_ack), .fw_err(fw_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_wrote(rsp_wrote),
    .rsp_err(rsp_err), .rsp_underflow(rsp_underflow),
    .rsp_overflow(rsp_overflow), .rsp_count(rsp_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // op: 0 insert, 1 delete; fail: answer the record with fw_err
  task automatic run_op(input logic op, input logic [1:0] bank, input logic [15:0] hash,
                        input logic fail, input int bp, input int rdly);
    int guard;
    int stall = bp;
    r_saw = 1'b0; r_state = 1'b0; r_bank = '0; r_idx = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bank; req_hash = hash;
    guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      if (fw_valid) begin
        if (r_saw) begin
          check("R9 record stable state", int'(fw_state), int'(r_state));
          check("R9 record stable index", int'(fw_index), int'(r_idx));
        end
        r_saw = 1'b1; r_state = fw_state; r_bank = fw_bank; r_idx = fw_index;
        if (stall > 0) begin
          stall--;
          @(negedge clk);
        end else begin
          fw_ready = 1'b1;
          @(negedge clk);
          fw_ready = 1'b0;
          if (fail) fw_err = 1'b1; else fw_ack = 1'b1;
          @(negedge clk);
          fw_err = 1'b0; fw_ack = 1'b0;
        end
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    check("R9 response arrives", int'(rsp_valid), 1);
    r_wrote = rsp_wrote; r_err = rsp_err; r_uf = rsp_underflow;
    r_of = rsp_overflow; r_cnt = rsp_count;
    for (int k = 0; k < rdly; k++) begin
      @(negedge clk);
      check("R9 response held valid", int'(rsp_valid), 1);
      check("R9 response count stable", int'(rsp_count), int'(r_cnt));
      check("R9 response wrote stable", int'(rsp_wrote), int'(r_wrote));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_init(output int cycles);
    cycles = 0;
    while (!init_done && cycles < 2000) begin @(negedge clk); cycles++; end
  endtask

  typedef struct packed {
    logic        op;
    logic [1:0]  bank;
    logic [15:0] hash;
    logic        fail;
    logic [1:0]  bp;
    logic        x_wrote;
    logic        x_state;
    logic        x_err;
    logic [3:0]  x_cnt;
    logic        x_uf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 16'h0005, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0}, // R4 first set
    '{1'b0, 2'd0, 16'h0045, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0}, // R2 R3 alias above index
    '{1'b0, 2'd1, 16'h0005, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0}, // R2 other bank, stalled
    '{1'b0, 2'd2, 16'h0010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0}, // R5 set rejected
    '{1'b0, 2'd2, 16'h0010, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0}, // R5 retry sets again
    '{1'b1, 2'd0, 16'h0005, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0}, // R6 decrement only
    '{1'b1, 2'd0, 16'h0005, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}, // R6 clear at 1->0
    '{1'b1, 2'd0, 16'h0005, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1}, // R7 underflow
    '{1'b0, 2'd0, 16'h0005, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0}, // R7 still zero after
    '{1'b1, 2'd1, 16'h0005, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0}, // R6 clear rejected
    '{1'b0, 2'd1, 16'h0005, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0}, // R6 counter was zeroed
    '{1'b0, 2'd3, 16'hFFFF, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0}, // R2 last counter
    '{1'b1, 2'd2, 16'h0010, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}  // R6 rollback delete
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int cyc;
    // R1 reset state and sweep length
    repeat (3) @(negedge clk);
    check("R1 init_done low in reset", int'(init_done), 0);
    check("R1 req_ready low in reset", int'(req_ready), 0);
    rst = 1'b0;
    wait_init(cyc);
    check("R1 sweep cycles", cyc, 256);

    foreach (VEC[i]) begin
      run_op(VEC[i].op, VEC[i].bank, VEC[i].hash, VEC[i].fail, int'(VEC[i].bp), 0);
      check($sformatf("R3 R4 R6 vec%0d wrote", i), int'(r_wrote), int'(VEC[i].x_wrote));
      check($sformatf("R9 vec%0d record seen", i), int'(r_saw), int'(VEC[i].x_wrote));
      if (VEC[i].x_wrote) begin
        check($sformatf("R4 R6 vec%0d state", i), int'(r_state), int'(VEC[i].x_state));
        check($sformatf("R2 vec%0d bank", i), int'(r_bank), int'(VEC[i].bank));
        check($sformatf("R2 vec%0d index", i), int'(r_idx), int'(VEC[i].hash[5:0]));
      end
      check($sformatf("R5 R6 vec%0d err", i), int'(r_err), int'(VEC[i].x_err));
      check($sformatf("R3 vec%0d count", i), int'(r_cnt), int'(VEC[i].x_cnt));
      check($sformatf("R7 vec%0d underflow", i), int'(r_uf), int'(VEC[i].x_uf));
      check($sformatf("R8 vec%0d overflow", i), int'(r_of), 0);
    end

    // R8 saturation on bank 3 index 0x20
    for (int k = 1; k <= 15; k++) begin
      run_op(1'b0, 2'd3, 16'h0020, 1'b0, 0, 0);
      check("R3 R8 ramp count", int'(r_cnt), k);
      check("R3 R8 ramp wrote", int'(r_wrote), (k == 1) ? 1 : 0);
    end
    run_op(1'b0, 2'd3, 16'h0020, 1'b0, 0, 2);
    check("R8 overflow flag", int'(r_of), 1);
    check("R8 saturated count", int'(r_cnt), 15);
    check("R8 no record", int'(r_saw), 0);
    run_op(1'b1, 2'd3, 16'h0020, 1'b0, 0, 0);
    check("R8 no wrap after saturate", int'(r_cnt), 14);
    check("R8 delete no record", int'(r_saw), 0);

    // R9 request held while busy: ready low right after acceptance
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_bank = 2'd0; req_hash = 16'h0007;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 ready low while busy", int'(req_ready), 0);
    while (!fw_valid) @(negedge clk);
    fw_ready = 1'b1; @(negedge clk); fw_ready = 1'b0;
    fw_ack = 1'b1; @(negedge clk); fw_ack = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check("R4 directed count", int'(rsp_count), 1);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;

    // R1 second reset clears nonzero counters
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready low on re-reset", int'(req_ready), 0);
    rst = 1'b0;
    wait_init(cyc);
    check("R1 re-sweep cycles", cyc, 256);
    run_op(1'b0, 2'd3, 16'h0020, 1'b0, 0, 0);
    check("R1 cleared counter sets bit", int'(r_wrote), 1);
    check("R1 cleared counter count", int'(r_cnt), 1);
    run_op(1'b1, 2'd0, 16'h0007, 1'b0, 0, 0);
    check("R1 cleared counter underflow", int'(r_uf), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule